// File: doc/BRIEF.md
# Panel Controller Register and Interrupt Bank

This block is the software-visible front of a simple flat-panel display controller. It holds six 32-bit words behind a flat byte-offset port: a control word, three timing words, a read-only status word and a subpanel word. Writes commit on the rising clock edge and reads are combinational from the offset. Some fields are mirrored on read, and some words return fixed reserved bits set to one. A small two-state machine tracks whether the controller is running. Each write to the control word that changes its run bit moves the machine and emits a one-cycle notification to the frame engine.

The frame engine reports three events: palette loaded, frame done and sync error. Each event sets a sticky flag. The flags drive one level interrupt line. Frame-done and palette-loaded each have their own enable bit. Sync error always reaches the line and cannot be masked. Starting the controller clears frame-done and palette-loaded. Stopping it clears sync error and sets frame-done, except when the palette-load mode written in that same word equals 1.

State machine: states `RS_IDLE` (stopped) and `RS_RUN` (running). There are two transitions. **start** (`RS_IDLE` to `RS_RUN`) fires on a control write with bit 0 = 1. **stop** (`RS_RUN` to `RS_IDLE`) fires on a control write with bit 0 = 0. Any other write leaves the state as it is.

Top module: `panel_ctl_regs`

## Requirements
- R1: After reset, reads return 0xfe000c34 at 0x00, 0x0000000f at 0x04, 0x00000000 at 0x08, 0xfc000000 at 0x0c, 0x00000000 at 0x10 and 0x00000000 at 0x14. After reset the interrupt and the change pulse are low.
- R2: A write to 0x00 stores the following fields:
  - palette-load mode from bits 21:20
  - TFT flag from bit 7
  - interrupt enables from bits 4:3 (bit 3 for frame-done, bit 4 for palette-loaded)
  - mono flag from bit 1
  - run bit from bit 0
  - the bits under 0x01cff300

  A read of 0x00 returns the OR of 0xfe000c34, the kept bits, the fields at the positions they were written, and a copy of the TFT flag at bit 23.
- R3: At 0x04 and 0x08, bits 9:0 (size minus one) and bits 31:10 (timing field) are stored. A read of 0x08 returns the written word. A read of 0x04 returns the written word ORed with 0x0000000f.
- R4: 0x0c stores the whole written word. A read returns it ORed with 0xfc000000.
- R5: 0x14 stores the written word ANDed with 0xa1ffffff.
- R6: 0x10 is read-only. It shows palette-loaded at bit 6, sync error at bit 2 and frame-done at bit 0. Writes to 0x10 change nothing.
- R7: A one-cycle pulse on an event input sets the matching flag. The flag stays set until a start or stop clears it.
- R8: The interrupt is high exactly when one of the following holds:
  - frame-done and enable bit 3 are both set
  - palette-loaded and enable bit 4 are both set
  - sync error is set
- R9: The start transition clears frame-done and palette-loaded. It leaves sync error unchanged.
- R10: The stop transition clears sync error. It sets frame-done unless the mode bits 21:20 of the stopping write equal 1.
- R11: The change pulse is high for exactly the one cycle after a control write that moves the state machine. It stays low for a control write whose bit 0 matches the current state.
- R12: Offsets other than the six listed, including unaligned ones, read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, commits on rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ev_pal_loaded_i | input | 1 | Palette-loaded event pulse |
| ev_frame_done_i | input | 1 | Frame-done event pulse |
| ev_sync_err_i | input | 1 | Sync-error event pulse |
| irq_o | output | 1 | Level interrupt |
| en_change_o | output | 1 | One-cycle pulse after the run state changes |

## Verification
The control readback is swept with a multiplicative hash over 32 words. This separates each field's position from the kept mask and the bit-23 mirror. The interrupt is tried with all 32 combinations of the three flags and the two enable bits, which separates the maskable sources from the unmaskable one. The stop transition is repeated for all four mode values, so that only mode 1 suppresses frame-done. A start with every flag set shows that sync error survives a start. Writes to the status word and to unknown and unaligned offsets are followed by reads of the surrounding words, which shows that nothing changed.

// File: rtl/panel_ctl_pkg.sv
`timescale 1ns/1ps
package panel_ctl_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_HTIM = 8'h04;
    localparam logic [7:0] OFS_VTIM = 8'h08;
    localparam logic [7:0] OFS_XTIM = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_SUBP = 8'h14;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] CTRL_RD_FIXED  = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] HTIM_RD_FIXED  = 32'h0000_000F;
    localparam logic [DATA_W-1:0] XTIM_RD_FIXED  = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUBP_WR_MASK   = 32'hA1FF_FFFF;

    localparam int unsigned CB_RUN   = 0;
    localparam int unsigned CB_MONO  = 1;
    localparam int unsigned CB_MASK  = 3;
    localparam int unsigned CB_TFT   = 7;
    localparam int unsigned CB_MODE  = 20;
    localparam int unsigned CB_TFT2  = 23;
    localparam int unsigned SB_FD    = 0;
    localparam int unsigned SB_SE    = 2;
    localparam int unsigned SB_PL    = 6;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic pal_loaded;
        logic sync_err;
        logic frame_done;
    } flag_set_t;
endpackage

// File: rtl/panel_ctl_fsm.sv
`timescale 1ns/1ps
module panel_ctl_fsm
    import panel_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic run_bit_i,
    output logic run_o,
    output logic start_o,
    output logic stop_o,
    output logic en_chg_o
);
    run_state_t st_q, st_d;
    logic chg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RS_IDLE;
            chg_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            chg_q <= start_o | stop_o;
        end
    end

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        stop_o  = 1'b0;
        unique case (st_q)
            RS_IDLE: if (ctl_wr_i && run_bit_i) begin
                st_d    = RS_RUN;
                start_o = 1'b1;
            end
            RS_RUN: if (ctl_wr_i && !run_bit_i) begin
                st_d   = RS_IDLE;
                stop_o = 1'b1;
            end
        endcase
    end

    assign run_o    = (st_q == RS_RUN);
    assign en_chg_o = chg_q;

    // R11
    en_pulse_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_chg_o |-> (run_o != $past(run_o)));

    // R11
    same_bit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && (run_bit_i == run_o)) |=> !en_chg_o);
endmodule

// File: rtl/panel_ctl_flags.sv
`timescale 1ns/1ps
module panel_ctl_flags
    import panel_ctl_pkg::*;
#(
    parameter int unsigned       MODE_W    = 2,
    parameter logic [MODE_W-1:0] SKIP_MODE = MODE_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_pl_i,
    input  logic              ev_fd_i,
    input  logic              ev_se_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [MODE_W-1:0] stop_mode_i,
    input  logic [1:0]        imask_i,
    output flag_set_t         flags_o,
    output logic              irq_o
);
    logic fd_q, pl_q, se_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_q <= 1'b0;
            pl_q <= 1'b0;
            se_q <= 1'b0;
        end else if (start_i) begin
            fd_q <= 1'b0;
            pl_q <= 1'b0;
            se_q <= se_q | ev_se_i;
        end else if (stop_i) begin
            fd_q <= fd_q | ev_fd_i | (stop_mode_i != SKIP_MODE);
            pl_q <= pl_q | ev_pl_i;
            se_q <= 1'b0;
        end else begin
            fd_q <= fd_q | ev_fd_i;
            pl_q <= pl_q | ev_pl_i;
            se_q <= se_q | ev_se_i;
        end
    end

    assign flags_o = '{pal_loaded: pl_q, sync_err: se_q, frame_done: fd_q};
    assign irq_o   = (fd_q & imask_i[0]) | (pl_q & imask_i[1]) | se_q;

    // R9
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!fd_q && !pl_q));

    // R10
    stop_clears_se_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !se_q);

    // R10
    stop_sets_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && (stop_mode_i != SKIP_MODE)) |=> fd_q);

    // R7
    se_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (se_q && !stop_i) |=> se_q);
endmodule

// File: rtl/panel_ctl_regs.sv
`timescale 1ns/1ps
module panel_ctl_regs
    import panel_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIM_W  = 10,
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_pal_loaded_i,
    input  logic              ev_frame_done_i,
    input  logic              ev_sync_err_i,
    output logic              irq_o,
    output logic              en_change_o
);
    localparam int unsigned TH_W = DATA_W - DIM_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_HTIM = ADDR_W'(OFS_HTIM);
    localparam logic [ADDR_W-1:0] A_VTIM = ADDR_W'(OFS_VTIM);
    localparam logic [ADDR_W-1:0] A_XTIM = ADDR_W'(OFS_XTIM);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SUBP = ADDR_W'(OFS_SUBP);

    logic              tft_q, mono_q;
    logic [MODE_W-1:0] mode_q;
    logic [1:0]        imask_q;
    logic [DATA_W-1:0] keep_q, xtim_q, subp_q;
    logic [DIM_W-1:0]  wid_q, hgt_q;
    logic [TH_W-1:0]   htim_q, vtim_q;

    logic      ctl_wr, run, start, stop;
    flag_set_t flags;

    assign ctl_wr = bus_we && (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tft_q   <= 1'b0;
            mono_q  <= 1'b0;
            mode_q  <= '0;
            imask_q <= '0;
            keep_q  <= '0;
            wid_q   <= '0;
            hgt_q   <= '0;
            htim_q  <= '0;
            vtim_q  <= '0;
            xtim_q  <= '0;
            subp_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    mode_q  <= bus_wdata[CB_MODE +: MODE_W];
                    tft_q   <= bus_wdata[CB_TFT];
                    imask_q <= bus_wdata[CB_MASK +: 2];
                    mono_q  <= bus_wdata[CB_MONO];
                    keep_q  <= bus_wdata & CTRL_KEEP_MASK;
                end
                A_HTIM: begin
                    wid_q  <= bus_wdata[DIM_W-1:0];
                    htim_q <= bus_wdata[DATA_W-1:DIM_W];
                end
                A_VTIM: begin
                    hgt_q  <= bus_wdata[DIM_W-1:0];
                    vtim_q <= bus_wdata[DATA_W-1:DIM_W];
                end
                A_XTIM: xtim_q <= bus_wdata;
                A_SUBP: subp_q <= bus_wdata & SUBP_WR_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL: bus_rdata = CTRL_RD_FIXED | keep_q
                              | (DATA_W'(tft_q)   << CB_TFT2)
                              | (DATA_W'(mode_q)  << CB_MODE)
                              | (DATA_W'(tft_q)   << CB_TFT)
                              | (DATA_W'(imask_q) << CB_MASK)
                              | (DATA_W'(mono_q)  << CB_MONO)
                              | (DATA_W'(run)     << CB_RUN);
            A_HTIM: bus_rdata = {htim_q, wid_q} | HTIM_RD_FIXED;
            A_VTIM: bus_rdata = {vtim_q, hgt_q};
            A_XTIM: bus_rdata = xtim_q | XTIM_RD_FIXED;
            A_STAT: bus_rdata = (DATA_W'(flags.pal_loaded) << SB_PL)
                              | (DATA_W'(flags.sync_err)   << SB_SE)
                              | (DATA_W'(flags.frame_done) << SB_FD);
            A_SUBP: bus_rdata = subp_q;
            default: bus_rdata = '0;
        endcase
    end

    panel_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr_i  (ctl_wr),
        .run_bit_i (bus_wdata[CB_RUN]),
        .run_o     (run),
        .start_o   (start),
        .stop_o    (stop),
        .en_chg_o  (en_change_o)
    );

    panel_ctl_flags #(
        .MODE_W    (MODE_W),
        .SKIP_MODE (MODE_W'(1))
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_pl_i     (ev_pal_loaded_i),
        .ev_fd_i     (ev_frame_done_i),
        .ev_se_i     (ev_sync_err_i),
        .start_i     (start),
        .stop_i      (stop),
        .stop_mode_i (bus_wdata[CB_MODE +: MODE_W]),
        .imask_i     (imask_q),
        .flags_o     (flags),
        .irq_o       (irq_o)
    );

    // R6
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_STAT) && !ev_pal_loaded_i
         && !ev_frame_done_i && !ev_sync_err_i) |=> $stable(flags));
endmodule

// File: tb/panel_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module panel_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_pl = 1'b0, ev_fd = 1'b0, ev_se = 1'b0;
    logic        irq, en_chg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    panel_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pal_loaded_i(ev_pl), .ev_frame_done_i(ev_fd), .ev_sync_err_i(ev_se),
        .irq_o(irq), .en_change_o(en_chg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic fd, input logic pl, input logic se);
        @(negedge clk);
        ev_fd = fd; ev_pl = pl; ev_se = se;
        @(negedge clk);
        ev_fd = 1'b0; ev_pl = 1'b0; ev_se = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_exp(input logic [31:0] d);
        return 32'hFE00_0C34 | (d & 32'h01CF_F300) | (d & 32'h0030_009B) | ({31'b0, d[7]} << 23);
    endfunction

    function automatic logic [31:0] stat_exp(input logic fd, input logic pl, input logic se);
        return ({31'b0, pl} << 6) | ({31'b0, se} << 2) | {31'b0, fd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 8'h00, 32'hFE00_0C34);
        rd("R1", 8'h04, 32'h0000_000F);
        rd("R1", 8'h08, 32'h0);
        rd("R1", 8'h0C, 32'hFC00_0000);
        rd("R1", 8'h10, 32'h0);
        rd("R1", 8'h14, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);
        chk("R1", {31'b0, en_chg}, 32'h0);

        // R2 control readback sweep
        for (int i = 0; i < 32; i++) begin
            d = 32'(i) * 32'h9E37_79B9;
            wr(8'h00, d);
            rd("R2", 8'h00, ctrl_exp(d));
        end
        wr(8'h00, 32'h0);

        // R3 R4 R5 timing and subpanel sweep
        for (int i = 0; i < 16; i++) begin
            d = 32'(i) * 32'h1357_9BDF + 32'h0102_0304;
            wr(8'h04, d); wr(8'h08, ~d); wr(8'h0C, d ^ 32'h5A5A_5A5A); wr(8'h14, d);
            rd("R3", 8'h04, d | 32'hF);
            rd("R3", 8'h08, ~d);
            rd("R4", 8'h0C, (d ^ 32'h5A5A_5A5A) | 32'hFC00_0000);
            rd("R5", 8'h14, d & 32'hA1FF_FFFF);
        end

        // R12 unknown and unaligned offsets
        wr(8'h0C, 32'h0000_1234);
        wr(8'h18, 32'hFFFF_FFFF); wr(8'h0E, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
        rd("R12", 8'h18, 32'h0);
        rd("R12", 8'h02, 32'h0);
        rd("R12", 8'hFC, 32'h0);
        rd("R12", 8'h0C, 32'hFC00_1234);
        rd("R12", 8'h00, 32'hFE00_0C34);

        // R7 sticky events while idle, R9 start keeps sync error
        pulse(1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rd("R7", 8'h10, stat_exp(1'b1, 1'b1, 1'b1));
        // R6 status write ignored
        wr(8'h10, 32'h0);
        rd("R6", 8'h10, stat_exp(1'b1, 1'b1, 1'b1));
        wr(8'h00, 32'h1);
        chk("R11", {31'b0, en_chg}, 32'h1);
        rd("R9", 8'h10, stat_exp(1'b0, 1'b0, 1'b1));
        @(negedge clk);
        chk("R11", {31'b0, en_chg}, 32'h0);
        wr(8'h00, 32'h1);
        chk("R11", {31'b0, en_chg}, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd("R6", 8'h10, stat_exp(1'b0, 1'b0, 1'b1));

        // R8 interrupt over all flag and enable combinations
        for (int c = 0; c < 32; c++) begin
            logic fd, pl, se;
            logic [1:0] m;
            fd = c[0]; pl = c[1]; se = c[2]; m = c[4:3];
            wr(8'h00, {27'b0, m, 3'b000});
            wr(8'h00, {27'b0, m, 3'b001});
            pulse(fd, pl, se);
            rd("R8", 8'h10, stat_exp(fd, pl, se));
            chk("R8", {31'b0, irq}, {31'b0, (fd & m[0]) | (pl & m[1]) | se});
        end

        // R10 stop behaviour per mode
        for (int m = 0; m < 4; m++) begin
            wr(8'h00, 32'h0);
            wr(8'h00, (32'(m) << 20) | 32'h1);
            pulse(1'b0, 1'b0, 1'b1);
            wr(8'h00, 32'(m) << 20);
            chk("R11", {31'b0, en_chg}, 32'h1);
            rd("R10", 8'h10, stat_exp(m != 1, 1'b0, 1'b0));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule